// File: doc/BRIEF.md
# Embedded-Clock Frame Lock Detector and Word Aligner

This block sits behind the clock-recovery front end of a serial receiver. It takes the recovered serial stream one bit at a time, qualified by a bit enable, and finds where each 12-bit frame begins. Every frame carries two embedded clock bits around a 10-bit payload. The block hunts for a synchronisation frame at every possible bit offset. It locks only when that frame is seen again exactly one frame later. While locked it checks the clock bits of each frame and hands out the payload of every good frame.

The status pin `no_lock` is active high: it reads 1 whenever the receiver is not locked, so it can drive the transmitter's "send sync" request directly. Lock is dropped only after a run of consecutive frames with broken clock bits, so a single disturbed frame does not force a new search. The output enable models the receiver's high-impedance data pins. It stays low until lock is reached. A low-going pulse on the power-down input clears all acquired state.

Neither stream can be stalled. The serial input has no ready: each cycle with `bit_en` high delivers one bit, and cycles with `bit_en` low are idle. The word output also has no ready: `word_valid` is a one-cycle strobe, and the consumer must take `word_data` in that cycle. Strobes are always at least twelve enabled bits apart.

Top module: `lkd_deser_lock`

## Requirements
- R1: After reset, `no_lock` is 1, `out_en` is 0 and `word_valid` is 0.
- R2: A frame is transmitted first bit first as: a clock bit of 1, ten payload bits least significant first, then a clock bit of 0. The sync frame is six 1 bits followed by six 0 bits, which is payload 0x01F.
- R3: `no_lock` falls in the cycle right after the enabled bit that completes a second sync frame at the same offset, twelve enabled bits after the first. A single sync frame followed by a non-sync frame does not lock.
- R4: While locked, each frame whose clock bits are 1 (first) and 0 (last) gives exactly one `word_valid` pulse, in the cycle after its last bit, with its payload on `word_data`.
- R5: `out_en` is always the inverse of `no_lock`, and `word_valid` is never high while `out_en` is low.
- R6: A frame with broken clock bits gives no strobe. The fourth such frame in a row raises `no_lock` in the cycle after its last bit, and lowers `out_en` in the same cycle.
- R7: One good frame after one to three bad frames restarts the bad-frame count, so three bad frames, one good frame and three bad frames keep the lock.
- R8: After lock is lost, the block searches for the sync frame at every bit offset and can lock again at a different offset.
- R9: While `pwrdn_n` is low the block is held unlocked with no strobes. After `pwrdn_n` returns high, lock needs two new sync frames, and data frames received before them give no strobe.
- R10: Cycles with `bit_en` low are ignored: no bit is taken in, whatever the value on `bit_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Active-low power-down; low clears all acquired state |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Recovered serial bit |
| no_lock | output | 1 | High when not locked, low when locked |
| out_en | output | 1 | Data output enable, high only while locked |
| word_valid | output | 1 | One-cycle strobe for a recovered word |
| word_data | output | 10 | Recovered payload |

## Verification
Several rules are checked on every cycle: the enable and status relation, that strobes only appear while enabled, that two strobes are never adjacent, and that lock changes and strobes only follow an enabled bit or power-down. The exact cycle of lock and of its loss, the two-sync confirmation, the count of four bad frames with its restart on a good frame, the payload bit order, and relocking at a shifted offset after power-down or loss can only be shown by the bench's frame sequences. The bench checks these against its own frame model.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } lock_state_e;

  typedef struct packed {
    logic sync_hit;
    logic clk_ok;
  } frame_flags_t;

endpackage

// File: rtl/lkd_window.sv
module lkd_window #(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] win_next
);

  logic [FRAME_W-1:0] win_q;

  // newest bit enters at the top, oldest bit sits at index 0
  assign win_next = {bit_in, win_q[FRAME_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (clr) begin
      win_q <= '0;
    end else if (shift_en) begin
      win_q <= win_next;
    end
  end

endmodule

// File: rtl/lkd_frame_eval.sv
module lkd_frame_eval
  import lkd_pkg::*;
#(
  parameter int DATA_W  = 10,
  localparam int FRAME_W = DATA_W + 2
) (
  input  logic [FRAME_W-1:0] win,
  output frame_flags_t       flags,
  output logic [DATA_W-1:0]  payload
);

  logic [FRAME_W-1:0] sync_pat;

  // sync frame: first half of the bits are ones, second half zeros
  for (genvar i = 0; i < FRAME_W; i++) begin : g_sync
    if (i < FRAME_W / 2) begin : g_one
      assign sync_pat[i] = 1'b1;
    end else begin : g_zero
      assign sync_pat[i] = 1'b0;
    end
  end

  assign flags.sync_hit = (win == sync_pat);
  assign flags.clk_ok   = win[0] & ~win[FRAME_W-1];
  assign payload        = win[FRAME_W-2:1];

endmodule

// File: rtl/lkd_lock_fsm.sv
module lkd_lock_fsm
  import lkd_pkg::*;
#(
  parameter int FRAME_W     = 12,
  parameter int SYNC_FRAMES = 2,
  parameter int LOSS_FRAMES = 4,
  localparam int PH_W  = $clog2(FRAME_W),
  localparam int SC_W  = $clog2(SYNC_FRAMES + 1),
  localparam int EC_W  = $clog2(LOSS_FRAMES + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bit_en,
  input  frame_flags_t flags,
  output logic         locked,
  output logic         emit
);

  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(FRAME_W - 1);
  localparam logic [SC_W-1:0] SC_NEED  = SC_W'(SYNC_FRAMES);
  localparam logic [EC_W-1:0] EC_LIMIT = EC_W'(LOSS_FRAMES - 1);

  lock_state_e     st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [SC_W-1:0] sc_q, sc_d;
  logic [EC_W-1:0] ec_q, ec_d;
  logic            boundary;

  assign boundary = bit_en && (ph_q == PH_LAST);
  assign locked   = (st_q == ST_LOCKED);
  assign emit     = boundary && locked && flags.clk_ok;

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    sc_d = sc_q;
    ec_d = ec_q;
    if (bit_en) begin
      ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      unique case (st_q)
        ST_HUNT: begin
          if (flags.sync_hit) begin
            ph_d = '0;
            ec_d = '0;
            if (SYNC_FRAMES <= 1) begin
              st_d = ST_LOCKED;
              sc_d = '0;
            end else begin
              st_d = ST_CONFIRM;
              sc_d = SC_W'(1);
            end
          end
        end
        ST_CONFIRM: begin
          if (boundary) begin
            if (flags.sync_hit) begin
              if (sc_q + 1'b1 >= SC_NEED) begin
                st_d = ST_LOCKED;
                sc_d = '0;
                ec_d = '0;
              end else begin
                sc_d = sc_q + 1'b1;
              end
            end else begin
              st_d = ST_HUNT;
              sc_d = '0;
            end
          end
        end
        ST_LOCKED: begin
          if (boundary) begin
            if (flags.clk_ok) begin
              ec_d = '0;
            end else if (ec_q >= EC_LIMIT) begin
              st_d = ST_HUNT;
              ec_d = '0;
            end else begin
              ec_d = ec_q + 1'b1;
            end
          end
        end
        default: begin
          st_d = ST_HUNT;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HUNT;
      ph_q <= '0;
      sc_q <= '0;
      ec_q <= '0;
    end else if (clr) begin
      st_q <= ST_HUNT;
      ph_q <= '0;
      sc_q <= '0;
      ec_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      sc_q <= sc_d;
      ec_q <= ec_d;
    end
  end

endmodule

// File: rtl/lkd_deser_lock.sv
module lkd_deser_lock
  import lkd_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SYNC_FRAMES = 2,
  parameter int LOSS_FRAMES = 4,
  localparam int FRAME_W    = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrdn_n,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic              no_lock,
  output logic              out_en,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data
);

  logic               clr;
  logic [FRAME_W-1:0] win_next;
  frame_flags_t       flags;
  logic [DATA_W-1:0]  payload;
  logic               locked;
  logic               emit;

  assign clr = ~pwrdn_n;

  lkd_window #(.FRAME_W(FRAME_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .shift_en (bit_en),
    .bit_in   (bit_in),
    .win_next (win_next)
  );

  lkd_frame_eval #(.DATA_W(DATA_W)) u_eval (
    .win     (win_next),
    .flags   (flags),
    .payload (payload)
  );

  lkd_lock_fsm #(
    .FRAME_W     (FRAME_W),
    .SYNC_FRAMES (SYNC_FRAMES),
    .LOSS_FRAMES (LOSS_FRAMES)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .bit_en (bit_en),
    .flags  (flags),
    .locked (locked),
    .emit   (emit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_data  <= '0;
    end else if (clr) begin
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= emit;
      if (emit) begin
        word_data <= payload;
      end
    end
  end

  assign no_lock = ~locked;
  assign out_en  = locked;

endmodule

// File: rtl/lkd_deser_lock_chk.sv
module lkd_deser_lock_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwrdn_n,
  input logic              bit_en,
  input logic              no_lock,
  input logic              out_en,
  input logic              word_valid,
  input logic [DATA_W-1:0] word_data
);

  AST_ENABLE_INVERSE: assert property (@(posedge clk) disable iff (!rst_n) out_en == !no_lock); // R5
  AST_STROBE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) word_valid |-> out_en); // R5
  AST_STROBE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n) word_valid |=> !word_valid); // R4
  AST_STROBE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n) word_valid |-> $past(bit_en)); // R10
  AST_LOCK_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n) $fell(no_lock) |-> $past(bit_en)); // R3
  AST_LOSS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(no_lock) |-> ($past(bit_en) || !$past(pwrdn_n))); // R6
  AST_PWRDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !pwrdn_n |=> (no_lock && !word_valid)); // R9
  AST_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n) word_valid |-> !$isunknown(word_data)); // R4

endmodule

bind lkd_deser_lock lkd_deser_lock_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwrdn_n    (pwrdn_n),
  .bit_en     (bit_en),
  .no_lock    (no_lock),
  .out_en     (out_en),
  .word_valid (word_valid),
  .word_data  (word_data)
);

// File: tb/tb_lkd_deser_lock.sv
`timescale 1ns/1ps
module tb_lkd_deser_lock;

  localparam int DW = 10;
  localparam int FW = DW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwrdn_n = 1'b1;
  logic          bit_en = 1'b0;
  logic          bit_in = 1'b0;
  logic          no_lock;
  logic          out_en;
  logic          word_valid;
  logic [DW-1:0] word_data;

  int n_chk = 0;
  int n_bad = 0;
  int strobes_seen = 0;
  int strobes_exp = 0;
  bit finished = 1'b0;
  bit m_locked = 1'b0;
  int m_err = 0;

  always #2 clk = ~clk;

  lkd_deser_lock dut (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .bit_en(bit_en), .bit_in(bit_in),
    .no_lock(no_lock), .out_en(out_en), .word_valid(word_valid), .word_data(word_data)
  );

  always @(negedge clk) if (rst_n && word_valid) strobes_seen++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R2: frame bit i is sent i-th; clock bits at both ends, payload LSB first
  function automatic logic [FW-1:0] mk_frame(logic [DW-1:0] d, logic s, logic p);
    logic [FW-1:0] f;
    f[0] = s;
    f[FW-2:1] = d;
    f[FW-1] = p;
    return f;
  endfunction

  localparam logic [DW-1:0] SYNC_DATA = 10'h01F;

  task automatic idle_cycle();
    bit_en = 1'b0;
    bit_in = 1'($urandom);
    @(posedge clk); #1;
  endtask

  task automatic send_bit(input logic b, input bit gaps);
    if (gaps && ($urandom % 4 == 0)) idle_cycle(); // R10: idle cycles with junk bits
    bit_en = 1'b1;
    bit_in = b;
    @(posedge clk); #1;
    bit_en = 1'b0;
  endtask

  task automatic send_frame(input logic [FW-1:0] f, input bit gaps);
    for (int i = 0; i < FW; i++) send_bit(f[i], gaps);
  endtask

  // locked-phase frame with model of strobes and bad-frame count
  task automatic locked_frame(input logic [DW-1:0] d, input bit good, input bit gaps, input string req);
    logic [FW-1:0] f;
    bit exp_strobe;
    f = good ? mk_frame(d, 1'b1, 1'b0) : mk_frame(d, ($urandom % 2) ? 1'b0 : 1'b1, 1'b1);
    if (!good && f[0] == 1'b1 && f[FW-1] == 1'b0) f[0] = 1'b0;
    send_frame(f, gaps);
    exp_strobe = m_locked && good;
    if (m_locked) begin
      if (good) m_err = 0;
      else begin
        m_err++;
        if (m_err == 4) begin m_locked = 1'b0; m_err = 0; end
      end
    end
    if (exp_strobe) strobes_exp++;
    check(word_valid == exp_strobe, {req, " strobe"}, word_valid, exp_strobe);
    if (exp_strobe) check(word_data == d, {req, " data"}, word_data, d);
    check(no_lock == !m_locked, {req, " no_lock"}, no_lock, !m_locked);
    check(out_en == m_locked, {req, " out_en (R5)"}, out_en, m_locked);
  endtask

  task automatic acquire(input string req);
    send_frame(mk_frame(SYNC_DATA, 1'b1, 1'b0), 1'b1);
    check(no_lock == 1'b1, {req, " first sync no lock"}, no_lock, 1);
    send_frame(mk_frame(SYNC_DATA, 1'b1, 1'b0), 1'b1);
    check(no_lock == 1'b0, {req, " second sync locks"}, no_lock, 0);
    check(word_valid == 1'b0, {req, " no strobe on confirm"}, word_valid, 0);
    m_locked = 1'b1;
    m_err = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(no_lock == 1'b1, "R1 no_lock", no_lock, 1);
    check(out_en == 1'b0, "R1 out_en", out_en, 0);
    check(word_valid == 1'b0, "R1 word_valid", word_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R3: single sync then non-sync does not lock
    send_frame(mk_frame(SYNC_DATA, 1'b1, 1'b0), 1'b0);
    send_frame(mk_frame('0, 1'b1, 1'b0), 1'b0);
    check(no_lock == 1'b1, "R3 single sync no lock", no_lock, 1);
    check(out_en == 1'b0, "R5 out_en low unlocked", out_en, 0);
    acquire("R3");

    // R2: sync frame while locked yields payload 0x01F
    locked_frame(SYNC_DATA, 1'b1, 1'b0, "R2 sync payload");
    locked_frame(10'h001, 1'b1, 1'b0, "R2 lsb first");
    locked_frame(10'h200, 1'b1, 1'b0, "R2 msb last");

    // R4 random payloads, R10 with junk idle gaps, occasional single bad frames
    for (int k = 0; k < 40; k++) begin
      logic [DW-1:0] d;
      bit good;
      d = DW'($urandom);
      good = !(($urandom % 6 == 0) && m_err < 2);
      locked_frame(d, good, 1'b1, good ? "R4 random good" : "R6 random bad");
    end
    locked_frame(10'h3A5, 1'b1, 1'b1, "R4 clean");

    // R7: 3 bad, 1 good, 3 bad keeps lock
    for (int k = 0; k < 3; k++) locked_frame(DW'($urandom), 1'b0, 1'b1, "R7 bad run a");
    locked_frame(10'h155, 1'b1, 1'b1, "R7 good resets count");
    for (int k = 0; k < 3; k++) locked_frame(DW'($urandom), 1'b0, 1'b1, "R7 bad run b");
    check(no_lock == 1'b0, "R7 still locked", no_lock, 0);

    // R6: fourth consecutive bad frame drops lock
    locked_frame(DW'($urandom), 1'b0, 1'b0, "R6 fourth bad");
    check(no_lock == 1'b1, "R6 lock lost", no_lock, 1);

    // R8: relock at a shifted offset
    for (int k = 0; k < 5; k++) send_bit(1'b0, 1'b0);
    acquire("R8");
    locked_frame(10'h2C3, 1'b1, 1'b1, "R8 data after relock");

    // R9: power-down cycle clears lock
    pwrdn_n = 1'b0;
    repeat (3) idle_cycle();
    check(no_lock == 1'b1, "R9 powered down", no_lock, 1);
    pwrdn_n = 1'b1;
    m_locked = 1'b0;
    @(posedge clk); #1;
    locked_frame(10'h0AA, 1'b1, 1'b0, "R9 no data before sync");
    acquire("R9");
    locked_frame(10'h3FF, 1'b1, 1'b1, "R9 data after relock");

    repeat (4) idle_cycle();
    check(strobes_seen == strobes_exp, "R4 total strobe count", strobes_seen, strobes_exp);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 4);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule